// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the interrupt-handling part of the control path of a small processor with 16-bit instructions. It owns the program counter, the instruction register and a one-level return-address register. At the end of each instruction it either fetches the next word from the instruction ROM, or it takes an external interrupt. It takes the interrupt only when the enable flag allows it.

When it takes an interrupt, the block first saves the return address over a four-phase request/acknowledge exchange with the PC unit. It then raises the interrupt acknowledge. Instead of a ROM word, it places a generated instruction in the instruction register. That instruction's opcode marks it as an interrupt call, and its operand carries the service-routine address. The PC jumps to that operand, and fetching continues inside the routine.

A return opcode restores the PC through a second four-phase exchange and sets the enable flag again. Normal fetching then resumes from the restored address. The surrounding core tells the block when an instruction has finished, and it supplies the ROM word addressed by the PC.

Top module: `irq_entry_seq`

## Requirements
- R1: The instruction register is split into an opcode in bits [15:12] and a 12-bit operand in bits [11:0]. The opcodes this block acts on are 4'hE (enable interrupts), 4'hD (disable interrupts), 4'hF (return from interrupt) and 4'hC (generated interrupt call). Every other opcode is fetched and left alone.
- R2: A request is looked at only when `done_i` is high. A request raised in the middle of an instruction leaves `pc_o`, `ir_o` and `irq_ack_o` unchanged until that instruction completes.
- R3: An interrupt is taken when `irq_i` is high at completion and the enable flag allows it. The instruction register is then loaded with {4'hC, `vector_i`} in place of a ROM word, and `irq_ack_o` stays high for two cycles while that word is present.
- R4: On entry, the address of the next instruction that has not yet run is saved. The PC is set to the operand of the generated word, and the first routine word is then fetched, leaving `pc_o` at vector+1.
- R5: Save and restore each use a request/acknowledge pair that completes a full four-phase cycle before the sequence moves on. The acknowledge rises only while its request is high, and a request is held until its acknowledge arrives.
- R6: A completing return opcode restores the PC from the saved value, sets the enable flag and fetches from the restored address, leaving `pc_o` at saved+1. A return takes precedence over a pending request at the same completion.
- R7: The enable flag is cleared on entry, so a request during the service routine is ignored. The save register is one level deep.
- R8: Enable and disable opcodes take effect when they complete. That new value already governs a request that is looked at in the same completion.
- R9: While reset is held, `pc_o` is the reset address (0), the enable flag is 0 and `irq_ack_o` is 0. After release, the word at address 0 is fetched and `pc_o` becomes 1.
- R10: A completion with no interrupt and no return loads the ROM word into the instruction register and adds one to the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 1 | External interrupt request, level |
| done_i | input | 1 | Current instruction has finished executing |
| rom_data_i | input | 16 | ROM word at address `pc_o` |
| vector_i | input | 12 | Service-routine start address |
| pc_o | output | 12 | Program counter (next fetch address) |
| ir_o | output | 16 | Instruction register |
| irq_ack_o | output | 1 | Interrupt acknowledge |
| int_en_o | output | 1 | Interrupt enable flag |

## Verification
The main entry and return path is exercised with a request held low, a request held high while interrupts are disabled, and a request that arrives while the enable opcode is completing. It is also exercised with a request during the service routine and a request held across a return. Together these separate a sequencer that looks at the request too early from one that uses a stale enable value, one that lets a nested entry through, and one that lets the request beat a return. Each request is raised several cycles before completion, which shows that nothing moves mid-instruction. Restoring two different return addresses through the same routine shows that the saved PC comes back exactly. A reset in the middle of an entry checks that the block returns to a clean state.

// File: rtl/ies_pkg.sv
package ies_pkg;
    localparam int INSTR_W = 16;
    localparam int OPC_W   = 4;
    localparam int ADDR_W  = INSTR_W - OPC_W;

    localparam logic [OPC_W-1:0] OPC_EI   = 4'hE;
    localparam logic [OPC_W-1:0] OPC_DI   = 4'hD;
    localparam logic [OPC_W-1:0] OPC_RETI = 4'hF;
    localparam logic [OPC_W-1:0] OPC_VINT = 4'hC;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_SV_REQ,
        ST_SV_REL,
        ST_VLOAD,
        ST_VJUMP,
        ST_RS_REQ,
        ST_RS_REL,
        ST_FETCH
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       int_en;
    } ctl_regs_t;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] sp;
        logic              sv_ack;
        logic              rs_ack;
    } pcstk_regs_t;
endpackage

// File: rtl/ies_ir.sv
module ies_ir
    import ies_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_rom_i,
    input  logic               load_virt_i,
    input  logic [INSTR_W-1:0] rom_i,
    input  logic [ADDR_W-1:0]  vector_i,
    output logic [INSTR_W-1:0] ir_o,
    output logic [OPC_W-1:0]   opcode_o,
    output logic [ADDR_W-1:0]  operand_o
);
    logic [INSTR_W-1:0] ir_d, ir_q;

    always_comb begin
        ir_d = ir_q;
        if (load_virt_i) begin
            ir_d = {OPC_VINT, vector_i};
        end else if (load_rom_i) begin
            ir_d = rom_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else begin
            ir_q <= ir_d;
        end
    end

    assign ir_o      = ir_q;
    assign opcode_o  = ir_q[INSTR_W-1 -: OPC_W];
    assign operand_o = ir_q[ADDR_W-1:0];

    // R3: a generated word never arrives together with a ROM load
    p_single_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_virt_i |-> !load_rom_i);
endmodule

// File: rtl/ies_pcstk.sv
module ies_pcstk
    import ies_pkg::*;
#(
    parameter logic [ies_pkg::ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pc_inc_i,
    input  logic              pc_load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              sv_req_i,
    output logic              sv_ack_o,
    input  logic              rs_req_i,
    output logic              rs_ack_o,
    output logic [ADDR_W-1:0] pc_o
);
    pcstk_regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.sv_ack = sv_req_i;
        r_d.rs_ack = rs_req_i;
        if (sv_req_i && !r_q.sv_ack) begin
            r_d.sp = r_q.pc;
        end
        if (rs_req_i && !r_q.rs_ack) begin
            r_d.pc = r_q.sp;
        end else if (pc_load_i) begin
            r_d.pc = load_addr_i;
        end else if (pc_inc_i) begin
            r_d.pc = r_q.pc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.pc     <= RESET_PC;
            r_q.sp     <= '0;
            r_q.sv_ack <= 1'b0;
            r_q.rs_ack <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sv_ack_o = r_q.sv_ack;
    assign rs_ack_o = r_q.rs_ack;
    assign pc_o     = r_q.pc;

    // R5: acknowledges only rise while their request is still held
    p_sv_ack_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.sv_ack) |-> sv_req_i);
    p_rs_ack_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.rs_ack) |-> rs_req_i);
    // R6: restore leaves the PC equal to the saved address
    p_restore_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.rs_ack) |-> r_q.pc == r_q.sp);
    // R4: the saved value stays put outside a save exchange
    p_sp_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sv_req_i) |-> $stable(r_q.sp));
endmodule

// File: rtl/ies_ctl.sv
module ies_ctl
    import ies_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_i,
    input  logic             done_i,
    input  logic [OPC_W-1:0] opcode_i,
    input  logic             sv_ack_i,
    input  logic             rs_ack_i,
    output logic             sv_req_o,
    output logic             rs_req_o,
    output logic             pc_inc_o,
    output logic             pc_load_o,
    output logic             ir_load_rom_o,
    output logic             ir_load_virt_o,
    output logic             irq_ack_o,
    output logic             int_en_o
);
    ctl_regs_t r_d, r_q;
    logic      en_eff;

    always_comb begin
        r_d            = r_q;
        sv_req_o       = 1'b0;
        rs_req_o       = 1'b0;
        pc_inc_o       = 1'b0;
        pc_load_o      = 1'b0;
        ir_load_rom_o  = 1'b0;
        ir_load_virt_o = 1'b0;
        irq_ack_o      = 1'b0;

        if (opcode_i == OPC_EI) begin
            en_eff = 1'b1;
        end else if (opcode_i == OPC_DI) begin
            en_eff = 1'b0;
        end else begin
            en_eff = r_q.int_en;
        end

        unique case (r_q.state)
            ST_RUN: begin
                if (done_i) begin
                    if (opcode_i == OPC_RETI) begin
                        r_d.state = ST_RS_REQ;
                    end else if (irq_i && en_eff) begin
                        r_d.int_en = en_eff;
                        r_d.state  = ST_SV_REQ;
                    end else begin
                        r_d.int_en    = en_eff;
                        ir_load_rom_o = 1'b1;
                        pc_inc_o      = 1'b1;
                    end
                end
            end
            ST_SV_REQ: begin
                sv_req_o = 1'b1;
                if (sv_ack_i) r_d.state = ST_SV_REL;
            end
            ST_SV_REL: begin
                if (!sv_ack_i) r_d.state = ST_VLOAD;
            end
            ST_VLOAD: begin
                irq_ack_o      = 1'b1;
                ir_load_virt_o = 1'b1;
                r_d.int_en     = 1'b0;
                r_d.state      = ST_VJUMP;
            end
            ST_VJUMP: begin
                irq_ack_o = 1'b1;
                pc_load_o = (opcode_i == OPC_VINT);
                r_d.state = ST_FETCH;
            end
            ST_RS_REQ: begin
                rs_req_o = 1'b1;
                if (rs_ack_i) r_d.state = ST_RS_REL;
            end
            ST_RS_REL: begin
                if (!rs_ack_i) begin
                    r_d.int_en = 1'b1;
                    r_d.state  = ST_FETCH;
                end
            end
            ST_FETCH: begin
                ir_load_rom_o = 1'b1;
                pc_inc_o      = 1'b1;
                r_d.state     = ST_RUN;
            end
            default: r_d.state = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state  <= ST_FETCH;
            r_q.int_en <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign int_en_o = r_q.int_en;

    // R5: a request is held until its acknowledge has arrived
    p_sv_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sv_req_o && !sv_ack_i |=> sv_req_o);
    p_rs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rs_req_o && !rs_ack_i |=> rs_req_o);
    // R5: a new request starts only after the previous acknowledge has dropped
    p_sv_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sv_req_o) |-> !sv_ack_i);
    p_rs_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rs_req_o) |-> !rs_ack_i);
    // R7: enable is low once the acknowledge pulse ends
    p_en_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_ack_o) |-> !int_en_o);
    // R7: entry is never started with the flag cleared
    p_entry_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_ack_o) |-> int_en_o);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import ies_pkg::*;
#(
    parameter logic [ies_pkg::ADDR_W-1:0] RESET_PC = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_i,
    input  logic               done_i,
    input  logic [INSTR_W-1:0] rom_data_i,
    input  logic [ADDR_W-1:0]  vector_i,
    output logic [ADDR_W-1:0]  pc_o,
    output logic [INSTR_W-1:0] ir_o,
    output logic               irq_ack_o,
    output logic               int_en_o
);
    logic             sv_req, sv_ack, rs_req, rs_ack;
    logic             pc_inc, pc_load, ld_rom, ld_virt;
    logic [OPC_W-1:0] opcode;
    logic [ADDR_W-1:0] operand;

    ies_ctl u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_i         (irq_i),
        .done_i        (done_i),
        .opcode_i      (opcode),
        .sv_ack_i      (sv_ack),
        .rs_ack_i      (rs_ack),
        .sv_req_o      (sv_req),
        .rs_req_o      (rs_req),
        .pc_inc_o      (pc_inc),
        .pc_load_o     (pc_load),
        .ir_load_rom_o (ld_rom),
        .ir_load_virt_o(ld_virt),
        .irq_ack_o     (irq_ack_o),
        .int_en_o      (int_en_o)
    );

    ies_ir u_ir (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_rom_i (ld_rom),
        .load_virt_i(ld_virt),
        .rom_i      (rom_data_i),
        .vector_i   (vector_i),
        .ir_o       (ir_o),
        .opcode_o   (opcode),
        .operand_o  (operand)
    );

    ies_pcstk #(.RESET_PC(RESET_PC)) u_pcstk (
        .clk        (clk),
        .rst_n      (rst_n),
        .pc_inc_i   (pc_inc),
        .pc_load_i  (pc_load),
        .load_addr_i(operand),
        .sv_req_i   (sv_req),
        .sv_ack_o   (sv_ack),
        .rs_req_i   (rs_req),
        .rs_ack_o   (rs_ack),
        .pc_o       (pc_o)
    );

    // R3: the generated call word is in the register as the acknowledge ends
    p_virt_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_ack_o) |-> ir_o[INSTR_W-1 -: OPC_W] == OPC_VINT);
    // R4: the jump lands on the routine address
    p_jump_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_ack_o) |-> pc_o == operand);
endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0;
    logic        done = 1'b0;
    logic [15:0] rom_data;
    logic [11:0] vector = 12'h100;
    logic [11:0] pc;
    logic [15:0] ir;
    logic        irq_ack;
    logic        int_en;

    int errors = 0;
    int checks = 0;
    int ack_cycles = 0;
    logic [15:0] ir_at_ack = '0;

    always #5 clk = ~clk;

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .done_i(done),
        .rom_data_i(rom_data), .vector_i(vector),
        .pc_o(pc), .ir_o(ir), .irq_ack_o(irq_ack), .int_en_o(int_en)
    );

    // ROM: EI at 2 and 8, DI at 6, return at 0x101, plain words elsewhere
    function automatic logic [15:0] rom_word(input logic [11:0] a);
        case (a)
            12'h002, 12'h008: rom_word = 16'hE000;
            12'h006:          rom_word = 16'hD000;
            12'h101:          rom_word = 16'hF000;
            default:          rom_word = {4'h1, a};
        endcase
    endfunction
    assign rom_data = rom_word(pc);

    always @(negedge clk) begin
        if (irq_ack) begin
            ack_cycles <= ack_cycles + 1;
            ir_at_ack  <= ir;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // fields: irq[30] pc[29:18] ir[17:2] en[1] ack[0]
    localparam logic [30:0] TBL [0:12] = '{
        {1'b0, 12'h002, 16'h1001, 1'b0, 1'b0},  // R10 plain fetch
        {1'b1, 12'h003, 16'hE000, 1'b0, 1'b0},  // R2 disabled request ignored
        {1'b0, 12'h004, 16'h1003, 1'b1, 1'b0},  // R8 EI completes
        {1'b1, 12'h101, 16'h1100, 1'b0, 1'b1},  // R3 R4 entry, saves 4
        {1'b1, 12'h102, 16'hF000, 1'b0, 1'b0},  // R7 nested ignored
        {1'b1, 12'h005, 16'h1004, 1'b1, 1'b0},  // R6 return beats request
        {1'b0, 12'h006, 16'h1005, 1'b1, 1'b0},  // R10
        {1'b0, 12'h007, 16'hD000, 1'b1, 1'b0},  // R10 fetch DI
        {1'b1, 12'h008, 16'h1007, 1'b0, 1'b0},  // R8 DI blocks same-cycle request
        {1'b0, 12'h009, 16'hE000, 1'b0, 1'b0},  // R10 fetch EI
        {1'b1, 12'h101, 16'h1100, 1'b0, 1'b1},  // R8 EI lets same-cycle request in
        {1'b0, 12'h102, 16'hF000, 1'b0, 1'b0},  // R7
        {1'b0, 12'h00A, 16'h1009, 1'b1, 1'b0}   // R6 restore of 9
    };

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset pc", pc, 12'h000);
        chk("R9 reset en", int_en, 1'b0);
        chk("R9 reset ack", irq_ack, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R9 first fetch pc", pc, 12'h001);
        chk("R9 first fetch ir", ir, 16'h1000);

        for (int i = 0; i < 13; i++) begin
            logic [11:0] pc_before;
            logic [15:0] ir_before;
            pc_before  = pc;
            ir_before  = ir;
            ack_cycles = 0;
            irq        = TBL[i][30];
            repeat (4) @(posedge clk);
            #1;
            chk("R2 pc held mid-instruction", pc, pc_before);
            chk("R2 ir held mid-instruction", ir, ir_before);
            chk("R2 no ack mid-instruction", ack_cycles, 0);
            done = 1'b1;
            @(posedge clk);
            #1;
            done = 1'b0;
            repeat (14) @(posedge clk);
            #1;
            chk("R4 R6 R10 pc", pc, TBL[i][29:18]);
            chk("R1 R10 ir", ir, TBL[i][17:2]);
            chk("R7 R8 enable", int_en, TBL[i][1]);
            chk("R3 ack length", ack_cycles, TBL[i][0] ? 2 : 0);
            if (TBL[i][0]) chk("R1 R3 generated word", ir_at_ack, 16'hC100);
        end

        // reset in the middle of an entry (flag is 1 here)
        irq = 1'b1;
        done = 1'b1;
        @(posedge clk);
        #1;
        done = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b0;
        irq = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R9 mid-entry reset pc", pc, 12'h000);
        chk("R9 mid-entry reset en", int_en, 1'b0);
        chk("R9 mid-entry reset ack", irq_ack, 1'b0);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        chk("R9 restart pc", pc, 12'h001);
        chk("R9 restart ir", ir, 16'h1000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R2: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule